// File: doc/BRIEF.md
# Paged Data Address Translator

This block turns a 16-bit logical data address into a wider physical bus address. Memory is split into 16 KB pages, and four programmable page-pointer registers hold page numbers. The two most significant bits of the logical address pick one of the four pointers. The page number in that pointer becomes the high part of the physical address. The low fourteen bits pass through unchanged as the offset within the page.

Software loads each pointer through a simple write port and can read any pointer back. The number of page-number bits is a parameter. Four bits give an 18-bit physical address, which covers a 256 KB space. Ten bits give a 24-bit physical address, which covers a 16 MB space.

A translation request is a logical address qualified by a valid strobe. The result and its valid flag are registered, so they appear one cycle after the request is accepted.

Top module: `pgx_translator`

## Requirements
- R1: After synchronous reset, pointers 0, 1, 2 and 3 hold page numbers 0, 1, 2 and 3, so the first 64 KB maps to itself. The response valid flag is low after reset.
- R2: Logical address bits [15:14] choose the pointer: 00 selects pointer 0, 01 selects pointer 1, 10 selects pointer 2 and 11 selects pointer 3.
- R3: The physical address is the selected page number in bits [PAGE_W+13:14], followed by logical bits [13:0] in bits [13:0]. For example, logical 0x8002 with pointer 2 holding 2 gives 0x08002, and with pointer 2 holding 8 it gives 0x20002.
- R4: `rsp_valid` equals the value `req_valid` had at the previous clock edge. `rsp_addr` changes only on an edge where a request is accepted, and otherwise holds its last value.
- R5: A pointer write with `wr_en` high stores `wr_data` into the pointer numbered `wr_sel` at the clock edge. Requests accepted at the same edge still use the old value. Requests accepted at any later edge use the new value.
- R6: `wr_data` bits at or above PAGE_W are discarded. They do not affect translation, and they read back as zero.
- R7: `rd_data` shows the pointer numbered `rd_sel`, zero-extended to 16 bits. It reflects writes from the previous edge onward. Pointers that are not written keep their values.
- R8: With PAGE_W = 10, the physical address is 24 bits wide and all ten page bits reach the output. Page 0x3FF with offset 0x3FFF gives 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pointer write strobe |
| wr_sel | input | 2 | Pointer number to write |
| wr_data | input | 16 | Page number to write; bits at or above PAGE_W are discarded |
| rd_sel | input | 2 | Pointer number to read back |
| rd_data | output | 16 | Read-back page number, zero-extended |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical data address |
| rsp_valid | output | 1 | Registered valid flag for the result |
| rsp_addr | output | PAGE_W+14 | Registered physical address |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. The first uses PAGE_W = 4, the 256 KB configuration. With so few page bits, writes of wide values show the discarding of upper bits both in read-back and in translation. The second uses PAGE_W = 10, the 16 MB configuration. It brings the full 24-bit output, and pages above 15, within reach. Its read-back keeps bits that the narrow copy drops for the same written value.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int LOG_W   = 16;
    localparam int OFF_W   = 14;
    localparam int SEL_W   = 2;
    localparam int NUM_PTR = 1 << SEL_W;
    localparam int REG_W   = 16;

    typedef logic [LOG_W-1:0] log_addr_t;
    typedef logic [SEL_W-1:0] ptr_sel_t;

    typedef struct packed {
        ptr_sel_t         sel;
        logic [OFF_W-1:0] off;
    } log_split_t;

    function automatic log_split_t split_addr(input log_addr_t a);
        log_split_t s;
        s.sel = a[LOG_W-1 -: SEL_W];
        s.off = a[OFF_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/pgx_ptr_bank.sv
module pgx_ptr_bank
    import pgx_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  ptr_sel_t                          wr_sel,
    input  logic [PAGE_W-1:0]                 wr_page,
    input  ptr_sel_t                          rd_sel,
    output logic [PAGE_W-1:0]                 rd_page,
    output logic [NUM_PTR-1:0][PAGE_W-1:0]    pages_o
);

    logic [NUM_PTR-1:0][PAGE_W-1:0] ptr_q;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[g] <= PAGE_W'(g);
            else if (wr_en && wr_sel == SEL_W'(g))
                ptr_q[g] <= wr_page;
        end

        // R1
        p_reset_ident_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> ptr_q[g] == PAGE_W'(g));
        // R5
        p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(wr_en) && $past(wr_sel) == SEL_W'(g))
            |-> ptr_q[g] == $past(wr_page));
        // R7
        p_unwritten_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !($past(wr_en) && $past(wr_sel) == SEL_W'(g)))
            |-> $stable(ptr_q[g]));
    end

    assign pages_o = ptr_q;
    assign rd_page = ptr_q[rd_sel];

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter int PAGE_W = 4,
    localparam int PHYS_W = PAGE_W + OFF_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  log_addr_t                      req_addr,
    input  logic [NUM_PTR-1:0][PAGE_W-1:0] pages_i,
    output logic                           rsp_valid,
    output logic [PHYS_W-1:0]              rsp_addr
);

    log_split_t        req_f;
    logic [PHYS_W-1:0] phys_d;

    always_comb begin
        req_f  = split_addr(req_addr);
        phys_d = {pages_i[req_f.sel], req_f.off};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid)
                rsp_addr <= phys_d;
        end
    end

    // R4
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rsp_valid == $past(req_valid));
    // R4
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req_valid)) |-> $stable(rsp_addr));
    // R3
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid))
        |-> rsp_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int PAGE_W = 4,
    localparam int PHYS_W = PAGE_W + pgx_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_sel,
    output logic [15:0]       rd_data,
    input  logic              req_valid,
    input  logic [15:0]       req_addr,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] rsp_addr
);

    logic [NUM_PTR-1:0][PAGE_W-1:0] pages;
    logic [PAGE_W-1:0]              rd_page;
    logic [PAGE_W-1:0]              wr_page;

    assign wr_page = wr_data[PAGE_W-1:0];

    if (PAGE_W < REG_W) begin : g_drop_hi
        logic unused_hi;
        assign unused_hi = ^wr_data[REG_W-1:PAGE_W];
    end

    assign rd_data = REG_W'(rd_page);

    pgx_ptr_bank #(.PAGE_W(PAGE_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_page (wr_page),
        .rd_sel  (rd_sel),
        .rd_page (rd_page),
        .pages_o (pages)
    );

    pgx_xlate #(.PAGE_W(PAGE_W)) u_xlate (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .pages_i   (pages),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr)
    );

endmodule

// File: tb/pgx_translator_test.sv
module pgx_translator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;

    logic [15:0] rd_n, rd_w;
    logic        rv_n, rv_w;
    logic [17:0] ra_n;
    logic [23:0] ra_w;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R1";
    bit started = 0;

    always #4 clk = ~clk;

    pgx_translator #(.PAGE_W(4)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv_n), .rsp_addr(ra_n));

    pgx_translator #(.PAGE_W(10)) uut_wide (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_w), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv_w), .rsp_addr(ra_w));

    // behavioural reference, index 0 = narrow, 1 = wide
    int mp [2][4];
    int ev [2];
    int ea [2];
    int pw [2] = '{4, 10};

    always @(posedge clk) begin
        started <= 1;
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                for (int i = 0; i < 4; i++) mp[d][i] = i;
                ev[d] = 0;
                ea[d] = 0;
            end else begin
                if (req_valid)
                    ea[d] = (mp[d][req_addr[15:14]] << 14) | int'(req_addr[13:0]);
                ev[d] = int'(req_valid);
                if (wr_en)
                    mp[d][wr_sel] = int'(wr_data) & ((1 << pw[d]) - 1);
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(cur_tag, "narrow rsp_valid", int'(rv_n), ev[0]);
            check(cur_tag, "wide rsp_valid",   int'(rv_w), ev[1]);
            check(cur_tag, "narrow rsp_addr",  int'(ra_n), ea[0]);
            check(cur_tag, "wide rsp_addr",    int'(ra_w), ea[1]);
            check(cur_tag, "narrow rd_data",   int'(rd_n), mp[0][rd_sel]);
            check(cur_tag, "wide rd_data",     int'(rd_w), mp[1][rd_sel]);
        end
    end

    task automatic drive(string tag, bit we, int ws, int wd, bit rv, int ra, int rs);
        @(negedge clk);
        #1;
        cur_tag   = tag;
        wr_en     = we;
        wr_sel    = 2'(ws);
        wr_data   = 16'(wd);
        req_valid = rv;
        req_addr  = 16'(ra);
        rd_sel    = 2'(rs);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset identity read-back and idle valid
        for (int i = 0; i < 4; i++) drive("R1", 0, 0, 0, 0, 0, i);
        @(negedge clk);
        check("R1", "rsp_valid after reset", int'(rv_n), 0);
        // R2: each selector value, identity map
        drive("R2", 0, 0, 0, 1, 'h0123, 0);
        drive("R2", 0, 0, 0, 1, 'h4567, 1);
        drive("R2", 0, 0, 0, 1, 'h8002, 2);
        drive("R2", 0, 0, 0, 1, 'hC001, 3);
        drive("R4", 0, 0, 0, 0, 'h1111, 3);
        // R3: documented examples
        drive("R3", 1, 2, 2, 0, 0, 2);
        drive("R3", 0, 0, 0, 1, 'h8002, 2);
        @(negedge clk);
        check("R3", "0x8002 with page 2", int'(ra_n), 'h08002);
        drive("R3", 1, 2, 8, 0, 0, 2);
        drive("R3", 0, 0, 0, 1, 'h8002, 2);
        @(negedge clk);
        check("R3", "0x8002 with page 8 narrow", int'(ra_n), 'h20002);
        check("R3", "0x8002 with page 8 wide", int'(ra_w), 'h20002);
        // R5: same-edge write and request use old value
        drive("R5", 1, 1, 'hF, 1, 'h4000, 1);
        @(negedge clk);
        check("R5", "same-edge uses old page", int'(ra_n), 'h04000);
        drive("R5", 0, 0, 0, 1, 'h4000, 1);
        @(negedge clk);
        check("R5", "next request uses new page", int'(ra_n), 'h3C000);
        // R6: upper bits discarded
        drive("R6", 1, 3, 'hFFF5, 0, 0, 3);
        drive("R6", 0, 0, 0, 1, 'hFFFF, 3);
        @(negedge clk);
        check("R6", "narrow read-back", int'(rd_n), 'h0005);
        check("R6", "narrow translation", int'(ra_n), 'h17FFF);
        check("R6", "wide read-back", int'(rd_w), 'h03F5);
        // R4: idle holds address
        drive("R4", 0, 0, 0, 0, 'h0000, 0);
        drive("R4", 0, 0, 0, 0, 'h4444, 1);
        // R8: full wide page
        drive("R8", 1, 0, 'h3FF, 0, 0, 0);
        drive("R8", 0, 0, 0, 1, 'h3FFF, 0);
        @(negedge clk);
        check("R8", "wide max address", int'(ra_w), 'hFFFFFF);
        // R7: mixed traffic
        for (int k = 0; k < 200; k++)
            drive("R7", 1'($urandom), int'($urandom % 4), int'($urandom % 65536),
                  1'($urandom), int'($urandom % 65536), int'($urandom % 4));
        drive("R7", 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule